// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell Array

This block is the logic core of a small programmable array: a fixed AND plane whose product terms feed eight output cells. Each cell ORs its own group of terms, applies a programmable polarity, and then behaves as a clocked register, a combinational gate with an always-on driver, a combinational I/O with a product-term enable, or a released pin used only as an input. The personality comes from a static fuse vector, a disable bit per product term, two global mode bits and two bits per cell. All of these are held constant during normal operation.

Each pin is presented as a data value and a tristate enable. The value seen on each pad comes back through `io_in`, so the surrounding logic decides whether the pad is driven by this block or from outside. Every pin is a level signal with no handshake. The combinational outputs settle within the cycle in which their inputs change. A registered cell changes only on the rising edge of `clk`.

Top module: `sop_cell_array`

## Requirements
- R1: Product term r is the AND of every column c for which `and_fuse[r*32+c]` is 1, and a term with no such column is 1. Column 2k carries array signal k and column 2k+1 carries its complement. Signals 0 to 7 are `ded_in[1]` to `ded_in[8]`, and signal 8+j is the feedback of cell j. Cell j owns rows 8j to 8j+7, and row 8j is its first term.
- R2: When `pt_off[r]` is 1, term r adds 0 to the OR sum. When a cell uses its first term as an enable and that term is disabled, the enable counts as true.
- R3: The mode family is decoded from the global bits. `cfg_cg0`=0 with `cfg_cg1`=1 selects the registered family. Both bits at 1 select the complex family. `cfg_cg1`=0 selects the simple family.
- R4: With `cfg_cl1[j]`=1 cell j passes its OR sum through unchanged, and with `cfg_cl1[j]`=0 it inverts the sum.
- R5: In the registered family a cell with `cfg_cl0[j]`=0 is registered. At each rising clock edge its register captures the inverse of the polarity-applied sum of all eight terms. `io_out[j]` shows the inverse of the register, and `io_oe[j]` equals the inverse of `ded_in[9]`.
- R6: A cell with `cfg_cl0[j]`=1 in the registered family, and every cell in the complex family, is a combinational I/O. Its data is the polarity-applied OR of terms 1 to 7, and its enable is term 0.
- R7: In the simple family, `cfg_cl0[j]`=0 gives a combinational output that ORs all eight terms with the enable held at 1. `cfg_cl0[j]`=1 gives a dedicated input with enable 0 and data 0.
- R8: The feedback of cell j takes the cell's own path when `cfg_cg1` is 1 for cells 1 to 6, or when `cfg_cg0` is 0 for cells 0 and 7. The own path is the register content for a registered cell and `io_in[j]` otherwise. On the other path, cell 0 takes `ded_in[9]`, cell 7 takes `ded_in[0]`, and the middle cells swap pins in the pairs 1/2, 3/4 and 5/6.
- R9: While `rst_n` is low every register is cleared to 0, so every registered pin reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for the registered cells |
| rst_n | input | 1 | Asynchronous active-low reset that clears the registers |
| ded_in | input | 10 | Dedicated input pins. Bit 0 and bit 9 are the two end pins, and bit 9 is also the shared enable of registered cells |
| io_in | input | 8 | Value present on each I/O pad |
| and_fuse | input | 2048 | AND-plane connection bits, 32 per product term |
| pt_off | input | 64 | Disable bit per product term |
| cfg_cg0 | input | 1 | Global mode bit 0 |
| cfg_cg1 | input | 1 | Global mode bit 1 |
| cfg_cl0 | input | 8 | Per-cell type bit |
| cfg_cl1 | input | 8 | Per-cell polarity bit |
| io_out | output | 8 | Data value per pin |
| io_oe | output | 8 | Tristate enable per pin |

## Verification
The bench builds the block with its default parameters: eight cells, eight terms per cell and eight core inputs. At these values the end cells and all three middle pairs of the feedback network are present at once. The registered, complex and simple families are swept with sparse random fuse patterns, random polarity and random disable bits. A bench model predicts every pin and enable each cycle, including the one-cycle lag through the registers. Directed cases cover the empty term, a disabled enable term, the pin swap for a middle cell, the end-pin feedback and the reset state.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    CELL_REG  = 2'd0,
    CELL_CIO  = 2'd1,
    CELL_COUT = 2'd2,
    CELL_DIN  = 2'd3
  } cell_kind_e;

  // Global bits pick the family, the local type bit picks the cell inside it.
  function automatic cell_kind_e decode_cell(input logic g0, input logic g1, input logic l0);
    if (!g0 && g1) return l0 ? CELL_CIO : CELL_REG;
    if (g0 && g1)  return CELL_CIO;
    return l0 ? CELL_DIN : CELL_COUT;
  endfunction

endpackage

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int NUM_COL = 32,
  parameter int NUM_PT  = 64
) (
  input  logic [NUM_COL-1:0]        cols,
  input  logic [NUM_PT*NUM_COL-1:0] fuse,
  output logic [NUM_PT-1:0]         term
);

  for (genvar r = 0; r < NUM_PT; r++) begin : g_row
    logic [NUM_COL-1:0] row_fuse;
    assign row_fuse = fuse[r*NUM_COL +: NUM_COL];
    // Unconnected columns read as 1, so an empty row is true.
    assign term[r] = &(cols | ~row_fuse);
  end

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_pkg::*;
#(
  parameter int PT_PER_CELL = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  cell_kind_e             kind,
  input  logic                   pol,
  input  logic [PT_PER_CELL-1:0] terms,
  input  logic [PT_PER_CELL-1:0] terms_off,
  input  logic                   oe_pin_n,
  input  logic                   own_pin,
  input  logic                   other_pin,
  input  logic                   own_path_sel,
  output logic                   pin_data,
  output logic                   pin_oe,
  output logic                   fb
);

  logic [PT_PER_CELL-1:0] live;
  logic                   sum;
  logic                   shaped;
  logic                   pt_en;
  logic                   q;

  assign live   = terms & ~terms_off;
  assign sum    = (kind == CELL_CIO) ? |live[PT_PER_CELL-1:1] : |live;
  assign shaped = pol ? sum : ~sum;
  assign pt_en  = terms_off[0] | terms[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= ~shaped;
  end

  always_comb begin
    pin_data = 1'b0;
    pin_oe   = 1'b0;
    case (kind)
      CELL_REG:  begin pin_data = ~q;     pin_oe = ~oe_pin_n; end
      CELL_CIO:  begin pin_data = shaped; pin_oe = pt_en;     end
      CELL_COUT: begin pin_data = shaped; pin_oe = 1'b1;      end
      default:   begin pin_data = 1'b0;   pin_oe = 1'b0;      end
    endcase
  end

  assign fb = own_path_sel ? ((kind == CELL_REG) ? q : own_pin) : other_pin;

  // R5: a registered pin shows the previous cycle's shaped sum
  a_r5_reg_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CELL_REG && $past(kind == CELL_REG) && $past(rst_n)) |-> (pin_data == $past(shaped)));

  // R5: registered cells follow the shared enable pin
  a_r5_shared_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CELL_REG) |-> (pin_oe == !oe_pin_n));

  // R7: a dedicated-input cell never drives
  a_r7_released: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CELL_DIN) |-> (!pin_oe && !pin_data));

  // R2: a disabled enable term leaves the pin enabled
  a_r2_off_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CELL_CIO && terms_off[0]) |-> pin_oe);

  // R2 R4: with every term disabled only the polarity shows
  a_r4_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CELL_COUT && (&terms_off)) |-> (pin_data == !pol));

endmodule

// File: rtl/sop_cell_array.sv
module sop_cell_array
  import sop_pkg::*;
#(
  parameter int NUM_CELLS   = 8,
  parameter int PT_PER_CELL = 8,
  parameter int NUM_CORE_IN = 8,
  localparam int NUM_DED    = NUM_CORE_IN + 2,
  localparam int NUM_SIG    = NUM_CORE_IN + NUM_CELLS,
  localparam int NUM_COL    = 2 * NUM_SIG,
  localparam int NUM_PT     = NUM_CELLS * PT_PER_CELL
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_DED-1:0]         ded_in,
  input  logic [NUM_CELLS-1:0]       io_in,
  input  logic [NUM_PT*NUM_COL-1:0]  and_fuse,
  input  logic [NUM_PT-1:0]          pt_off,
  input  logic                       cfg_cg0,
  input  logic                       cfg_cg1,
  input  logic [NUM_CELLS-1:0]       cfg_cl0,
  input  logic [NUM_CELLS-1:0]       cfg_cl1,
  output logic [NUM_CELLS-1:0]       io_out,
  output logic [NUM_CELLS-1:0]       io_oe
);

  logic [NUM_CELLS-1:0] fb;
  logic [NUM_SIG-1:0]   sig;
  logic [NUM_COL-1:0]   cols;
  logic [NUM_PT-1:0]    term_raw;

  assign sig = {fb, ded_in[NUM_CORE_IN:1]};

  for (genvar k = 0; k < NUM_SIG; k++) begin : g_col
    assign cols[2*k]   = sig[k];
    assign cols[2*k+1] = ~sig[k];
  end

  sop_and_plane #(
    .NUM_COL (NUM_COL),
    .NUM_PT  (NUM_PT)
  ) u_plane (
    .cols (cols),
    .fuse (and_fuse),
    .term (term_raw)
  );

  for (genvar j = 0; j < NUM_CELLS; j++) begin : g_cell
    logic       other_pin;
    logic       own_sel;
    cell_kind_e kind;

    assign kind = decode_cell(cfg_cg0, cfg_cg1, cfg_cl0[j]);

    if (j == 0) begin : g_end_lo
      assign other_pin = ded_in[NUM_DED-1];
      assign own_sel   = ~cfg_cg0;
    end else if (j == NUM_CELLS - 1) begin : g_end_hi
      assign other_pin = ded_in[0];
      assign own_sel   = ~cfg_cg0;
    end else if (j % 2 == 1) begin : g_mid_odd
      assign other_pin = io_in[j+1];
      assign own_sel   = cfg_cg1;
    end else begin : g_mid_even
      assign other_pin = io_in[j-1];
      assign own_sel   = cfg_cg1;
    end

    sop_macrocell #(
      .PT_PER_CELL (PT_PER_CELL)
    ) u_cell (
      .clk          (clk),
      .rst_n        (rst_n),
      .kind         (kind),
      .pol          (cfg_cl1[j]),
      .terms        (term_raw[j*PT_PER_CELL +: PT_PER_CELL]),
      .terms_off    (pt_off[j*PT_PER_CELL +: PT_PER_CELL]),
      .oe_pin_n     (ded_in[NUM_DED-1]),
      .own_pin      (io_in[j]),
      .other_pin    (other_pin),
      .own_path_sel (own_sel),
      .pin_data     (io_out[j]),
      .pin_oe       (io_oe[j]),
      .fb           (fb[j])
    );
  end

endmodule

// File: tb/test_sop_cell_array.sv
module test_sop_cell_array;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [9:0]    ded_in = '0;
  logic [7:0]    io_in = '0;
  logic [2047:0] and_fuse = '0;
  logic [63:0]   pt_off = '0;
  logic          cfg_cg0 = 1'b0;
  logic          cfg_cg1 = 1'b1;
  logic [7:0]    cfg_cl0 = '0;
  logic [7:0]    cfg_cl1 = '0;
  logic [7:0]    io_out;
  logic [7:0]    io_oe;

  logic [9:0] nx_ded = '0;
  logic [7:0] nx_io = '0;
  logic [7:0] qm = '0;
  logic [7:0] nq, exp_out, exp_oe;
  logic [7:0] kreg, kcio;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sop_cell_array i_sop_cell_array (
    .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .io_in(io_in),
    .and_fuse(and_fuse), .pt_off(pt_off), .cfg_cg0(cfg_cg0), .cfg_cg1(cfg_cg1),
    .cfg_cl0(cfg_cl0), .cfg_cl1(cfg_cl1), .io_out(io_out), .io_oe(io_oe)
  );

  task automatic check(input string req, input logic got, input logic expv, input string what);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, got, expv);
    end
  endtask

  // Independent reference model of the whole array
  task automatic model_eval();
    logic [7:0]  fbv;
    logic [15:0] sg;
    logic [63:0] raw;
    bit regf, cplx;
    regf = !cfg_cg0 && cfg_cg1;
    cplx = cfg_cg0 && cfg_cg1;
    for (int j = 0; j < 8; j++) begin
      bit own, other;
      kreg[j] = regf && !cfg_cl0[j];
      kcio[j] = cplx || (regf && cfg_cl0[j]);
      own = (j == 0 || j == 7) ? !cfg_cg0 : cfg_cg1;
      if (j == 0)      other = ded_in[9];
      else if (j == 7) other = ded_in[0];
      else if (j % 2)  other = io_in[j+1];
      else             other = io_in[j-1];
      fbv[j] = own ? (kreg[j] ? qm[j] : io_in[j]) : other;
    end
    for (int k = 0; k < 16; k++) sg[k] = (k < 8) ? ded_in[k+1] : fbv[k-8];
    for (int r = 0; r < 64; r++) begin
      bit t;
      t = 1;
      for (int c = 0; c < 32; c++)
        if (and_fuse[r*32+c]) t = t & ((c % 2) ? !sg[c/2] : sg[c/2]);
      raw[r] = t;
    end
    for (int j = 0; j < 8; j++) begin
      bit s, v;
      s = 0;
      for (int p = 0; p < 8; p++)
        if (!(kcio[j] && p == 0) && !pt_off[j*8+p] && raw[j*8+p]) s = 1;
      v = cfg_cl1[j] ? s : !s;
      nq[j] = qm[j];
      if (kreg[j]) begin
        exp_out[j] = !qm[j]; exp_oe[j] = !ded_in[9]; nq[j] = !v;
      end else if (kcio[j]) begin
        exp_out[j] = v; exp_oe[j] = pt_off[j*8] || raw[j*8];
      end else if (!cfg_cg1 && !cfg_cl0[j]) begin
        exp_out[j] = v; exp_oe[j] = 1;
      end else begin
        exp_out[j] = 0; exp_oe[j] = 0;
      end
    end
  endtask

  task automatic run_cycle(input string ov);
    @(negedge clk);
    ded_in = nx_ded;
    io_in  = nx_io;
    #1;
    model_eval();
    for (int j = 0; j < 8; j++) begin
      string req;
      if (ov != "") req = ov;
      else if (kreg[j]) req = "R5";
      else if (kcio[j]) req = "R6";
      else req = "R7";
      check(req, io_out[j], exp_out[j], $sformatf("io_out[%0d]", j));
      check(req, io_oe[j], exp_oe[j], $sformatf("io_oe[%0d]", j));
    end
    @(posedge clk);
    #1;
    if (rst_n) qm = nq;
  endtask

  task automatic rand_fuses();
    and_fuse = '0;
    for (int r = 0; r < 64; r++) begin
      int n;
      n = $urandom % 4;
      for (int k = 0; k < n; k++) begin
        int s;
        s = $urandom % 16;
        and_fuse[r*32 + 2*s + ($urandom % 2)] = 1'b1;
      end
      pt_off[r] = (($urandom % 8) == 0);
    end
  endtask

  task automatic rand_run(input bit g0, input bit g1, input bit rand_cl0, input string ov);
    cfg_cg0 = g0;
    cfg_cg1 = g1;
    cfg_cl0 = rand_cl0 ? 8'($urandom) : 8'h00;
    for (int blk = 0; blk < 4; blk++) begin
      rand_fuses();
      cfg_cl1 = 8'($urandom);
      for (int c = 0; c < 10; c++) begin
        nx_ded = 10'($urandom);
        nx_io  = 8'($urandom);
        run_cycle(ov);
      end
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    // R9: registered mode held in reset
    rand_fuses();
    cfg_cg0 = 0; cfg_cg1 = 1; cfg_cl0 = 8'h00; cfg_cl1 = 8'hA5;
    for (int c = 0; c < 3; c++) begin
      nx_ded = 10'($urandom); nx_io = 8'($urandom);
      run_cycle("R9");
      check("R9", io_out[2], 1'b1, "registered pin during reset");
    end
    rst_n = 1;

    // Random sweeps over all families
    rand_run(0, 1, 0, "");
    rand_run(0, 1, 1, "");
    rand_run(1, 1, 1, "");
    rand_run(1, 0, 1, "");
    rand_run(1, 0, 0, "R8");
    rand_run(0, 0, 1, "R3");
    cfg_cg0 = 1; cfg_cg1 = 1; cfg_cl0 = 8'h00;
    rand_run(1, 1, 0, "R3");

    // R1: empty term in the simple family
    cfg_cg0 = 1; cfg_cg1 = 0; cfg_cl0 = 8'h00; cfg_cl1 = 8'hFF;
    and_fuse = '0; pt_off = ~64'h1;
    nx_ded = '0; nx_io = '0;
    run_cycle("R1");
    check("R1", io_out[0], 1'b1, "empty term");
    check("R2", io_out[4], 1'b0, "all terms disabled");
    and_fuse[0] = 1'b1;
    nx_ded[1] = 1'b0;
    run_cycle("R1");
    check("R1", io_out[0], 1'b0, "single literal low");
    nx_ded[1] = 1'b1;
    run_cycle("R1");
    check("R1", io_out[0], 1'b1, "single literal high");
    and_fuse[1] = 1'b1;
    run_cycle("R1");
    check("R1", io_out[0], 1'b0, "true and complement");

    // R4: inverted polarity
    and_fuse = '0; cfg_cl1 = 8'hFE;
    run_cycle("R4");
    check("R4", io_out[0], 1'b0, "inverted empty term");

    // R2: disabled enable term in the complex family
    cfg_cg0 = 1; cfg_cg1 = 1; cfg_cl1 = 8'hFF;
    and_fuse = '0; and_fuse[24*32+0] = 1'b1; and_fuse[24*32+1] = 1'b1;
    pt_off = '0; pt_off[24] = 1'b1;
    run_cycle("R2");
    check("R2", io_oe[3], 1'b1, "disabled enable term");
    pt_off[24] = 1'b0;
    run_cycle("R2");
    check("R2", io_oe[3], 1'b0, "false enable term");

    // R8: middle cell swaps with its partner in the simple family
    cfg_cg0 = 1; cfg_cg1 = 0; cfg_cl0 = 8'h00; cfg_cl1 = 8'hFF;
    and_fuse = '0; pt_off = '1;
    pt_off[8] = 1'b0; and_fuse[8*32 + 18] = 1'b1;
    nx_io = 8'b0000_0100;
    run_cycle("R8");
    check("R8", io_out[1], 1'b1, "cell1 reads pin 2");
    nx_io = 8'b0000_0010;
    run_cycle("R8");
    check("R8", io_out[1], 1'b0, "cell1 ignores own pin");
    pt_off[0] = 1'b0; and_fuse[16] = 1'b1;
    nx_ded = 10'h200;
    run_cycle("R8");
    check("R8", io_out[0], 1'b1, "end cell reads end pin high");
    nx_ded = 10'h000;
    run_cycle("R8");
    check("R8", io_out[0], 1'b0, "end cell reads end pin low");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule